// File: doc/BRIEF.md
# Special Register Access Unit

This unit executes the class of 32-bit instructions that move values between the general-purpose register file and a sparse bank of special-purpose registers. It also performs the atomic bit-set and bit-clear operations on the machine status word. The pipeline presents an instruction word with an issue strobe, the value read from the source general register and the current program counter. One clock later the unit returns a destination-register write (strobe, index, data) and a one-cycle illegal-access flag. Hardware update ports let exception logic load the exception registers and overwrite the status word.

The unit keeps storage for every writable special register, including the memory-management and floating-point status words, which it holds as plain storage only. It has no state machine. Each issued instruction is decoded in one cycle into one of six operation kinds. IDLE means no issue or a foreign opcode. READ moves a special register to a general register and WRITE moves a general register to a special register. SETB and CLRB are the status bit operations, and BAD is a malformed encoding. The result register takes the kind's output values at the next edge. Operation kinds can be issued back to back on every cycle.

Top module: `sreg_access_unit`

## Requirements
- R1: An instruction is acted on only when `issue_i` is high and bits [31:26] equal 6'b100101. Otherwise, at the next edge, `wr_en_o` and `illegal_o` are low and no special register changes.
- R2: Fields use bit 31 as the MSB. The destination is [25:21] and the source is [20:16]. The kind is [15:14] (10 read, 11 write, 00 bit operation), and the 14-bit selector or immediate is [13:0]. Results appear on the outputs exactly one clock after issue, and `wr_idx_o` equals the destination field.
- R3: A write (kind 11, destination field zero) to one of 0x0001, 0x0007, 0x0800, 0x0802 or 0x1000–0x1005 stores `src_val_i` there. Readable targets return that value on a later read.
- R4: Writes to 0x0000, 0x0003, 0x0005, 0x000B, 0x000D, 0x2000–0x200B or unmapped selectors raise `illegal_o` and change nothing. Reading 0x1005 is illegal, but writing it is legal.
- R5: A read (kind 10, source field zero) from a selector outside the readable map raises `illegal_o` for one cycle and returns zero as write data.
- R6: Set (kind 00, sub-field [20:16] = 0) returns the old status word and ORs the zero-extended immediate into the status word at the same edge.
- R7: Clear (kind 00, sub-field = 1) returns the old status word and clears each status bit whose immediate bit is 1. Bits 31:14 are never affected.
- R8: A destination field of 0 suppresses `wr_en_o`, while the special register side effect still takes place.
- R9: After reset the outputs are low and every writable and exception register reads zero.
- R10: Selector 0x0000 returns `pc_i` as sampled at issue. Selector 0x2000+i, for i below VER_COUNT, returns VER_SEED+i.
- R11: `hw_exc_we_i` loads the exception address, status, data and branch target registers (0x0003, 0x0005, 0x000D, 0x000B). `hw_stat_we_i` loads the status word and overrides any instruction update in the same cycle.
- R12: Kind 01, a nonzero source field on a read, a nonzero destination field on a write, or a sub-field above 1 on a bit operation is illegal. Such an instruction raises `illegal_o`, returns no write and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | Instruction valid this cycle |
| instr_i | input | 32 | Instruction word |
| src_val_i | input | 32 | Value of the source general register |
| pc_i | input | 32 | Program counter of the issued instruction |
| hw_stat_we_i | input | 1 | Hardware load of the status word |
| hw_stat_i | input | 32 | Status word loaded by hardware |
| hw_exc_we_i | input | 1 | Hardware load of the exception registers |
| hw_exc_addr_i | input | 32 | Exception address value |
| hw_exc_stat_i | input | 32 | Exception status value |
| hw_exc_data_i | input | 32 | Exception data value |
| hw_br_tgt_i | input | 32 | Branch target value |
| wr_en_o | output | 1 | Destination register write strobe |
| wr_idx_o | output | 5 | Destination register index |
| wr_data_o | output | 32 | Destination register write data |
| illegal_o | output | 1 | Illegal access, one-cycle pulse |
| status_o | output | 32 | Current status word |

## Verification
The checker watches several rules on every cycle. Outputs only ever follow an issue, register 0 is never written and illegal reads carry zero data. Set and clear update the status word exactly as OR and AND-NOT of the immediate and return the prior word. The status word holds still when nothing touches it, and a hardware load wins over an instruction. Only the bench's scenarios show that the address maps are right. These scenarios cover which selectors read back what was written, the read-only and write-only corners, version constants, exception loads and the rejection of malformed encodings.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
    localparam int XW = 32;
    localparam int AW = 14;
    localparam int RW = 5;
    localparam logic [5:0] OPC_SREG = 6'b100101;

    typedef enum logic [2:0] {
        OP_IDLE, OP_READ, OP_WRITE, OP_SETB, OP_CLRB, OP_BAD
    } sreg_op_e;

    typedef struct packed {
        sreg_op_e          op;
        logic [RW-1:0]     dst;
        logic [AW-1:0]     field;
    } sreg_dec_t;

    localparam logic [AW-1:0] A_PC    = 14'h0000;
    localparam logic [AW-1:0] A_STAT  = 14'h0001;
    localparam logic [AW-1:0] A_EADDR = 14'h0003;
    localparam logic [AW-1:0] A_ESTAT = 14'h0005;
    localparam logic [AW-1:0] A_FPST  = 14'h0007;
    localparam logic [AW-1:0] A_BRTGT = 14'h000B;
    localparam logic [AW-1:0] A_EDATA = 14'h000D;
    localparam logic [AW-1:0] A_STKLO = 14'h0800;
    localparam logic [AW-1:0] A_STKHI = 14'h0802;
    localparam logic [AW-1:0] A_MPID  = 14'h1000;
    localparam logic [AW-1:0] A_MZONE = 14'h1001;
    localparam logic [AW-1:0] A_MIDX  = 14'h1002;
    localparam logic [AW-1:0] A_MLO   = 14'h1003;
    localparam logic [AW-1:0] A_MHI   = 14'h1004;
    localparam logic [AW-1:0] A_MSRCH = 14'h1005;
    localparam logic [AW-1:0] A_VER   = 14'h2000;

    // storage slots for plain writable registers (status kept apart)
    localparam int NSLOT = 9;
    localparam logic [3:0] SLOT_NONE = 4'hF;

    function automatic logic [3:0] wr_slot(input logic [AW-1:0] a);
        case (a)
            A_FPST:  return 4'd0;
            A_STKLO: return 4'd1;
            A_STKHI: return 4'd2;
            A_MPID:  return 4'd3;
            A_MZONE: return 4'd4;
            A_MIDX:  return 4'd5;
            A_MLO:   return 4'd6;
            A_MHI:   return 4'd7;
            A_MSRCH: return 4'd8;
            default: return SLOT_NONE;
        endcase
    endfunction
endpackage

// File: rtl/sreg_decode.sv
module sreg_decode
    import sreg_pkg::*;
(
    input  logic          issue_i,
    input  logic [XW-1:0] instr_i,
    output sreg_dec_t     dec_o
);
    logic [5:0]    major;
    logic [RW-1:0] f_d;
    logic [RW-1:0] f_s;
    logic [1:0]    kind;

    assign major = instr_i[31:26];
    assign f_d   = instr_i[25:21];
    assign f_s   = instr_i[20:16];
    assign kind  = instr_i[15:14];

    always_comb begin
        dec_o.dst   = f_d;
        dec_o.field = instr_i[AW-1:0];
        dec_o.op    = OP_IDLE;
        if (issue_i && major == OPC_SREG) begin
            unique case (kind)
                2'b11:   dec_o.op = (f_d == '0) ? OP_WRITE : OP_BAD;
                2'b10:   dec_o.op = (f_s == '0) ? OP_READ  : OP_BAD;
                2'b00: begin
                    if (f_s == 5'd0)      dec_o.op = OP_SETB;
                    else if (f_s == 5'd1) dec_o.op = OP_CLRB;
                    else                  dec_o.op = OP_BAD;
                end
                default: dec_o.op = OP_BAD;
            endcase
        end
    end
endmodule

// File: rtl/sreg_bank.sv
module sreg_bank
    import sreg_pkg::*;
#(
    parameter int            VER_COUNT = 12,
    parameter logic [XW-1:0] VER_SEED  = 32'hA500_0000
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_addr_i,
    input  logic [XW-1:0] pc_i,
    output logic [XW-1:0] rd_data_o,
    output logic          rd_hit_o,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [XW-1:0] wr_data_i,
    output logic          wr_hit_o,
    input  logic          bit_en_i,
    input  logic [XW-1:0] bit_val_i,
    input  logic          hw_stat_we_i,
    input  logic [XW-1:0] hw_stat_i,
    input  logic          hw_exc_we_i,
    input  logic [XW-1:0] hw_exc_addr_i,
    input  logic [XW-1:0] hw_exc_stat_i,
    input  logic [XW-1:0] hw_exc_data_i,
    input  logic [XW-1:0] hw_br_tgt_i,
    output logic [XW-1:0] status_o
);
    localparam int VIW = (VER_COUNT > 1) ? $clog2(VER_COUNT) : 1;
    localparam logic [AW-1:0] VER_END = A_VER + AW'(VER_COUNT);

    logic [XW-1:0] status_q;
    logic [XW-1:0] exc_addr_q, exc_stat_q, exc_data_q, br_tgt_q;
    logic [XW-1:0] slot_q [NSLOT];
    logic [XW-1:0] ver_w  [VER_COUNT];
    logic [3:0]    wsel, rsel;
    logic [VIW-1:0] vidx;
    logic [AW-1:0]  voff;

    for (genvar g = 0; g < VER_COUNT; g++) begin : g_ver
        assign ver_w[g] = VER_SEED + XW'(g);
    end

    assign wsel     = wr_slot(wr_addr_i);
    assign rsel     = wr_slot(rd_addr_i);
    assign wr_hit_o = (wr_addr_i == A_STAT) || (wsel != SLOT_NONE);
    assign voff     = rd_addr_i - A_VER;
    assign vidx     = voff[VIW-1:0];
    assign status_o = status_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  status_q <= '0;
        else if (hw_stat_we_i)                       status_q <= hw_stat_i;
        else if (bit_en_i)                           status_q <= bit_val_i;
        else if (wr_en_i && wr_addr_i == A_STAT)     status_q <= wr_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exc_addr_q <= '0;
            exc_stat_q <= '0;
            exc_data_q <= '0;
            br_tgt_q   <= '0;
        end else if (hw_exc_we_i) begin
            exc_addr_q <= hw_exc_addr_i;
            exc_stat_q <= hw_exc_stat_i;
            exc_data_q <= hw_exc_data_i;
            br_tgt_q   <= hw_br_tgt_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NSLOT; i++) slot_q[i] <= '0;
        end else if (wr_en_i && wsel != SLOT_NONE) begin
            slot_q[wsel] <= wr_data_i;
        end
    end

    always_comb begin
        rd_hit_o  = 1'b1;
        rd_data_o = '0;
        if (rd_addr_i >= A_VER && rd_addr_i < VER_END) begin
            rd_data_o = ver_w[vidx];
        end else begin
            case (rd_addr_i)
                A_PC:    rd_data_o = pc_i;
                A_STAT:  rd_data_o = status_q;
                A_EADDR: rd_data_o = exc_addr_q;
                A_ESTAT: rd_data_o = exc_stat_q;
                A_BRTGT: rd_data_o = br_tgt_q;
                A_EDATA: rd_data_o = exc_data_q;
                A_FPST, A_STKLO, A_STKHI, A_MPID, A_MZONE,
                A_MIDX, A_MLO, A_MHI: rd_data_o = slot_q[rsel];
                default: rd_hit_o = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/sreg_access_unit.sv
module sreg_access_unit
    import sreg_pkg::*;
#(
    parameter int            VER_COUNT = 12,
    parameter logic [31:0]   VER_SEED  = 32'hA500_0000
)(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        issue_i,
    input  logic [31:0] instr_i,
    input  logic [31:0] src_val_i,
    input  logic [31:0] pc_i,
    input  logic        hw_stat_we_i,
    input  logic [31:0] hw_stat_i,
    input  logic        hw_exc_we_i,
    input  logic [31:0] hw_exc_addr_i,
    input  logic [31:0] hw_exc_stat_i,
    input  logic [31:0] hw_exc_data_i,
    input  logic [31:0] hw_br_tgt_i,
    output logic        wr_en_o,
    output logic [4:0]  wr_idx_o,
    output logic [31:0] wr_data_o,
    output logic        illegal_o,
    output logic [31:0] status_o
);
    sreg_dec_t     dec;
    logic [XW-1:0] rdata, status_w, imm_ext, bit_val;
    logic          rhit, whit, bit_en, bank_we;
    logic          en_n, ill_n;
    logic [XW-1:0] data_n;

    sreg_decode u_dec (
        .issue_i (issue_i),
        .instr_i (instr_i),
        .dec_o   (dec)
    );

    assign imm_ext = {{(XW-AW){1'b0}}, dec.field};
    assign bit_en  = (dec.op == OP_SETB) || (dec.op == OP_CLRB);
    assign bit_val = (dec.op == OP_SETB) ? (status_w | imm_ext) : (status_w & ~imm_ext);
    assign bank_we = (dec.op == OP_WRITE);

    sreg_bank #(.VER_COUNT(VER_COUNT), .VER_SEED(VER_SEED)) u_bank (
        .clk           (clk),
        .rst_n         (rst_n),
        .rd_addr_i     (dec.field),
        .pc_i          (pc_i),
        .rd_data_o     (rdata),
        .rd_hit_o      (rhit),
        .wr_en_i       (bank_we),
        .wr_addr_i     (dec.field),
        .wr_data_i     (src_val_i),
        .wr_hit_o      (whit),
        .bit_en_i      (bit_en),
        .bit_val_i     (bit_val),
        .hw_stat_we_i  (hw_stat_we_i),
        .hw_stat_i     (hw_stat_i),
        .hw_exc_we_i   (hw_exc_we_i),
        .hw_exc_addr_i (hw_exc_addr_i),
        .hw_exc_stat_i (hw_exc_stat_i),
        .hw_exc_data_i (hw_exc_data_i),
        .hw_br_tgt_i   (hw_br_tgt_i),
        .status_o      (status_w)
    );

    assign status_o = status_w;

    // output values per operation kind
    always_comb begin
        en_n   = 1'b0;
        ill_n  = 1'b0;
        data_n = '0;
        unique case (dec.op)
            OP_IDLE:  ;
            OP_READ: begin
                en_n   = (dec.dst != '0);
                ill_n  = !rhit;
                data_n = rhit ? rdata : '0;
            end
            OP_WRITE: ill_n = !whit;
            OP_SETB, OP_CLRB: begin
                en_n   = (dec.dst != '0);
                data_n = status_w;
            end
            OP_BAD:   ill_n = 1'b1;
            default:  ill_n = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_en_o   <= 1'b0;
            wr_idx_o  <= '0;
            wr_data_o <= '0;
            illegal_o <= 1'b0;
        end else begin
            wr_en_o   <= en_n;
            wr_idx_o  <= dec.dst;
            wr_data_o <= data_n;
            illegal_o <= ill_n;
        end
    end
endmodule

// File: rtl/sreg_access_chk.sv
module sreg_access_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        issue_i,
    input logic [31:0] instr_i,
    input logic        hw_stat_we_i,
    input logic [31:0] hw_stat_i,
    input logic        wr_en_o,
    input logic [4:0]  wr_idx_o,
    input logic [31:0] wr_data_o,
    input logic        illegal_o,
    input logic [31:0] status_o
);
    logic        is_bits, is_set, is_clr;
    logic [31:0] imm;

    assign is_bits = issue_i && instr_i[31:26] == 6'b100101 && instr_i[15:14] == 2'b00;
    assign is_set  = is_bits && instr_i[20:16] == 5'd0;
    assign is_clr  = is_bits && instr_i[20:16] == 5'd1;
    assign imm     = {18'b0, instr_i[13:0]};

    assert_outputs_follow_issue_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o || illegal_o) |-> $past(issue_i));

    assert_no_r0_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (wr_idx_o != 5'd0));

    assert_illegal_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal_o && wr_en_o) |-> (wr_data_o == 32'd0));

    assert_set_or_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_set && !hw_stat_we_i) |=> (status_o == ($past(status_o) | $past(imm))));

    assert_clr_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (is_clr && !hw_stat_we_i) |=> (status_o == ($past(status_o) & ~$past(imm))));

    assert_old_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((is_set || is_clr) && instr_i[25:21] != 5'd0) |=> (wr_en_o && wr_data_o == $past(status_o)));

    assert_hw_priority_R11: assert property (@(posedge clk) disable iff (!rst_n)
        hw_stat_we_i |=> (status_o == $past(hw_stat_i)));

    assert_stat_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!issue_i && !hw_stat_we_i) |=> $stable(status_o));

    assert_illegal_no_change_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal_o && !$past(hw_stat_we_i)) |-> $stable(status_o));
endmodule

bind sreg_access_unit sreg_access_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .issue_i      (issue_i),
    .instr_i      (instr_i),
    .hw_stat_we_i (hw_stat_we_i),
    .hw_stat_i    (hw_stat_i),
    .wr_en_o      (wr_en_o),
    .wr_idx_o     (wr_idx_o),
    .wr_data_o    (wr_data_o),
    .illegal_o    (illegal_o),
    .status_o     (status_o)
);

// File: tb/sreg_access_unit_tb_top.sv
`timescale 1ns/1ps
module sreg_access_unit_tb_top;
    localparam logic [31:0] SEED = 32'hA500_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_i = 1'b0;
    logic [31:0] instr_i = '0, src_val_i = '0, pc_i = '0;
    logic        hw_stat_we_i = 1'b0, hw_exc_we_i = 1'b0;
    logic [31:0] hw_stat_i = '0, hw_exc_addr_i = '0, hw_exc_stat_i = '0;
    logic [31:0] hw_exc_data_i = '0, hw_br_tgt_i = '0;
    logic        wr_en_o, illegal_o;
    logic [4:0]  wr_idx_o;
    logic [31:0] wr_data_o, status_o;

    always #2.5 clk = ~clk;

    sreg_access_unit #(.VER_COUNT(12), .VER_SEED(SEED)) dut_i (
        .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .instr_i(instr_i),
        .src_val_i(src_val_i), .pc_i(pc_i), .hw_stat_we_i(hw_stat_we_i),
        .hw_stat_i(hw_stat_i), .hw_exc_we_i(hw_exc_we_i),
        .hw_exc_addr_i(hw_exc_addr_i), .hw_exc_stat_i(hw_exc_stat_i),
        .hw_exc_data_i(hw_exc_data_i), .hw_br_tgt_i(hw_br_tgt_i),
        .wr_en_o(wr_en_o), .wr_idx_o(wr_idx_o), .wr_data_o(wr_data_o),
        .illegal_o(illegal_o), .status_o(status_o)
    );

    typedef struct {
        int          due;
        logic        we;
        logic [4:0]  idx;
        logic [31:0] data;
        logic        ill;
        logic [31:0] stat;
        string       req;
    } exp_t;

    exp_t        sb[$];
    int          cyc = 0;
    int          n_cmp = 0, n_bad = 0;
    logic [31:0] m_stat = '0;
    bit          done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] i_rd(input logic [4:0] rd, input logic [13:0] a);
        return {6'b100101, rd, 5'd0, 2'b10, a};
    endfunction
    function automatic logic [31:0] i_wr(input logic [4:0] ra, input logic [13:0] a);
        return {6'b100101, 5'd0, ra, 2'b11, a};
    endfunction
    function automatic logic [31:0] i_set(input logic [4:0] rd, input logic [13:0] k);
        return {6'b100101, rd, 5'd0, 2'b00, k};
    endfunction
    function automatic logic [31:0] i_clr(input logic [4:0] rd, input logic [13:0] k);
        return {6'b100101, rd, 5'd1, 2'b00, k};
    endfunction

    // driver: drives one cycle of stimulus and pushes the expected result
    task automatic op(input logic iss, input logic [31:0] ins, input logic [31:0] src,
                      input logic we, input logic [4:0] idx, input logic [31:0] data,
                      input logic ill, input string req);
        exp_t e;
        @(posedge clk); #1;
        hw_stat_we_i = 1'b0;
        hw_exc_we_i  = 1'b0;
        issue_i   = iss;
        instr_i   = ins;
        src_val_i = src;
        e.due = cyc + 1; e.we = we; e.idx = idx; e.data = data;
        e.ill = ill; e.stat = m_stat; e.req = req;
        sb.push_back(e);
    endtask

    // monitor: compares at the falling edge
    always @(negedge clk) begin
        if (rst_n && sb.size() > 0 && sb[0].due == cyc) begin
            exp_t e;
            e = sb.pop_front();
            n_cmp++;
            if (wr_en_o !== e.we || illegal_o !== e.ill || status_o !== e.stat ||
                (e.we && (wr_idx_o !== e.idx || wr_data_o !== e.data))) begin
                n_bad++;
                $display("FAIL %s: actual en=%b idx=%0d data=%h ill=%b stat=%h expected en=%b idx=%0d data=%h ill=%b stat=%h",
                         e.req, wr_en_o, wr_idx_o, wr_data_o, illegal_o, status_o,
                         e.we, e.idx, e.data, e.ill, e.stat);
            end
        end else if (rst_n && !done && (wr_en_o !== 1'b0 || illegal_o !== 1'b0)) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R1: actual en=%b ill=%b on idle cycle expected en=0 ill=0", wr_en_o, illegal_o);
        end
    end

    initial begin
        #(10000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        n_cmp++;
        if (wr_en_o !== 1'b0 || illegal_o !== 1'b0 || status_o !== 32'd0) begin
            n_bad++;
            $display("FAIL R9: actual en=%b ill=%b stat=%h expected 0 0 0", wr_en_o, illegal_o, status_o);
        end

        // reset contents, pc and version constants
        op(1, i_rd(5'd3, 14'h0800), 0, 1, 5'd3, 32'd0, 0, "R9");
        pc_i = 32'h1234_5678;
        op(1, i_rd(5'd4, 14'h0000), 0, 1, 5'd4, 32'h1234_5678, 0, "R10");
        op(1, i_rd(5'd5, 14'h2000), 0, 1, 5'd5, SEED, 0, "R10");
        op(1, i_rd(5'd6, 14'h200B), 0, 1, 5'd6, SEED + 32'd11, 0, "R10");
        op(1, i_rd(5'd7, 14'h200C), 0, 1, 5'd7, 32'd0, 1, "R5");
        op(1, i_rd(5'd7, 14'h0004), 0, 1, 5'd7, 32'd0, 1, "R5");

        // writes and read-back, back to back
        op(1, i_wr(5'd2, 14'h0800), 32'hDEAD_0001, 0, 5'd0, 0, 0, "R3");
        op(1, i_rd(5'd8, 14'h0800), 0, 1, 5'd8, 32'hDEAD_0001, 0, "R3");
        op(1, i_wr(5'd2, 14'h1004), 32'h0BAD_F00D, 0, 5'd0, 0, 0, "R3");
        op(1, i_rd(5'd9, 14'h1004), 0, 1, 5'd9, 32'h0BAD_F00D, 0, "R3");
        op(1, i_wr(5'd2, 14'h0007), 32'h0000_0055, 0, 5'd0, 0, 0, "R3");
        op(1, i_rd(5'd10, 14'h0007), 0, 1, 5'd10, 32'h0000_0055, 0, "R2");

        // status word: write, set, clear
        m_stat = 32'h0000_00F0;
        op(1, i_wr(5'd2, 14'h0001), 32'h0000_00F0, 0, 5'd0, 0, 0, "R3");
        m_stat = 32'h0000_0FFF;
        op(1, i_set(5'd11, 14'h0F0F), 0, 1, 5'd11, 32'h0000_00F0, 0, "R6");
        m_stat = 32'h0000_0F0C;
        op(1, i_clr(5'd12, 14'h00F3), 0, 1, 5'd12, 32'h0000_0FFF, 0, "R7");
        m_stat = 32'hFFFF_0000;
        op(1, i_wr(5'd2, 14'h0001), 32'hFFFF_0000, 0, 5'd0, 0, 0, "R3");
        op(1, i_clr(5'd13, 14'h3FFF), 0, 1, 5'd13, 32'hFFFF_0000, 0, "R7");
        m_stat = 32'hFFFF_3FFF;
        op(1, i_set(5'd14, 14'h3FFF), 0, 1, 5'd14, 32'hFFFF_0000, 0, "R6");

        // destination register 0
        m_stat = 32'hFFFF_3FFE;
        op(1, i_clr(5'd0, 14'h0001), 0, 0, 5'd0, 0, 0, "R8");
        op(1, i_rd(5'd0, 14'h0001), 0, 0, 5'd0, 0, 0, "R8");
        op(1, i_rd(5'd15, 14'h0001), 0, 1, 5'd15, 32'hFFFF_3FFE, 0, "R8");

        // read-only and write-only corners
        op(1, i_wr(5'd2, 14'h0000), 32'd1, 0, 5'd0, 0, 1, "R4");
        op(1, i_wr(5'd2, 14'h0003), 32'd7, 0, 5'd0, 0, 1, "R4");
        op(1, i_wr(5'd2, 14'h2000), 32'd7, 0, 5'd0, 0, 1, "R4");
        op(1, i_rd(5'd16, 14'h0003), 0, 1, 5'd16, 32'd0, 0, "R4");
        op(1, i_rd(5'd17, 14'h2000), 0, 1, 5'd17, SEED, 0, "R4");
        op(1, i_rd(5'd18, 14'h1005), 0, 1, 5'd18, 32'd0, 1, "R4");
        op(1, i_wr(5'd2, 14'h1005), 32'd9, 0, 5'd0, 0, 0, "R4");

        // not issued / foreign opcode
        op(0, i_set(5'd3, 14'h0001), 0, 0, 5'd0, 0, 0, "R1");
        op(1, {6'b100100, 5'd3, 5'd0, 2'b00, 14'h0001}, 0, 0, 5'd0, 0, 0, "R1");

        // malformed encodings
        op(1, {6'b100101, 5'd1, 5'd0, 2'b01, 14'h0001}, 0, 0, 5'd0, 0, 1, "R12");
        op(1, {6'b100101, 5'd3, 5'd2, 2'b10, 14'h0001}, 0, 0, 5'd0, 0, 1, "R12");
        op(1, {6'b100101, 5'd3, 5'd2, 2'b00, 14'h0003}, 0, 0, 5'd0, 0, 1, "R12");
        op(1, {6'b100101, 5'd4, 5'd2, 2'b11, 14'h0800}, 32'h1111_1111, 0, 5'd0, 0, 1, "R12");
        op(1, i_rd(5'd19, 14'h0800), 0, 1, 5'd19, 32'hDEAD_0001, 0, "R12");

        // hardware exception load
        op(0, 32'd0, 0, 0, 5'd0, 0, 0, "R11");
        hw_exc_we_i = 1'b1;
        hw_exc_addr_i = 32'hAAAA_0003; hw_exc_stat_i = 32'hAAAA_0005;
        hw_exc_data_i = 32'hAAAA_000D; hw_br_tgt_i  = 32'hAAAA_000B;
        op(1, i_rd(5'd20, 14'h0003), 0, 1, 5'd20, 32'hAAAA_0003, 0, "R11");
        op(1, i_rd(5'd21, 14'h0005), 0, 1, 5'd21, 32'hAAAA_0005, 0, "R11");
        op(1, i_rd(5'd22, 14'h000B), 0, 1, 5'd22, 32'hAAAA_000B, 0, "R11");
        op(1, i_rd(5'd23, 14'h000D), 0, 1, 5'd23, 32'hAAAA_000D, 0, "R11");

        // hardware status load wins over a set in the same cycle
        m_stat = 32'h0000_0ABC;
        op(1, i_set(5'd24, 14'h0001), 0, 1, 5'd24, 32'hFFFF_3FFE, 0, "R11");
        hw_stat_we_i = 1'b1;
        hw_stat_i    = 32'h0000_0ABC;
        op(1, i_rd(5'd25, 14'h0001), 0, 1, 5'd25, 32'h0000_0ABC, 0, "R11");
        op(0, 32'd0, 0, 0, 5'd0, 0, 0, "R1");

        repeat (3) @(posedge clk);
        @(negedge clk);
        done = 1;
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL R2: actual %0d results missing expected 0", sb.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule